// File: doc/BRIEF.md
# Cache Management Access Port

This block lets software reach a set-associative cache array directly through a management address window, without going through the normal tag lookup. The way and index are taken straight from fixed fields of the request address. A management read returns the stored line whether or not its tag matches. Both the data word and the tag are checked and corrected with SECDED codes, and a status code tells data errors apart from tag errors. A management write replaces the line's data and tag and computes fresh check bits for both. The old contents are dropped without eviction and without any error report.

The array holds 4 ways of 64 indexes, with one 64-bit word per line. The data is protected by a (72,64) code and a 20-bit tag by a (26,20) code. Two side registers can be read through a register-select port. The read-tag register captures the tag from every management read. The error-tag register keeps the address and raw tag of the last read that reported an uncorrectable error.

Requests use a valid/ready handshake. The block accepts a request when `req_valid` and `req_ready` are both high on a clock edge. `req_ready` goes low only while a read response is waiting and `rsp_ready` is low. That back-pressure holds the request, which the requester must keep stable. A read response is offered from the cycle after acceptance and stays unchanged until `rsp_ready` takes it. Writes produce no response.

A test-only injection input flips chosen bits of the codewords as a write stores them. It is tied to zero in normal use.

Top module: `cache_mgmt_port`

## Requirements
- R1: The line is selected by address bits [10:9] (way) and [8:3] (index). A read returns that line's data no matter what the upper address bits or the stored tag hold.
- R2: A write stores the data and a 20-bit tag built as tag[19] = address bit 20 (valid), tag[18] = address bit 19 (dirty) and tag[17:0] = address[38:21]. A read of an error-free line returns status 0.
- R3: When the stored data codeword has exactly one flipped bit (data, check or parity bit), the read returns the original data with status 1.
- R4: When the stored data codeword has two flipped bits and the tag is error free or has one flipped bit, the read returns status 3.
- R5: When the stored tag codeword has one flipped bit and the data is error free or has one flipped bit, the read returns status 2 and the read-tag register holds the corrected tag.
- R6: When the stored tag codeword has two flipped bits, the read returns status 4. This holds whatever the data holds, so an uncorrectable tag outranks every other condition.
- R7: One cycle after a read response first appears, the read-tag register (reg_sel = 0) holds the corrected tag in bits [19:0] and the raw stored tag check bits {parity, check[4:0]} in bits [25:20]. The upper bits read as zero.
- R8: A read with status 3 or 4 loads the error-tag register (reg_sel = 1) with the request address in bits [58:20] and the raw stored 20-bit tag field in bits [19:0]. Reads with status 0, 1 or 2 leave the register unchanged.
- R9: A write to a line that held corrupted codewords produces no status and leaves no trace: the next read of that line returns the new data with status 0.
- R10: `req_ready` is low exactly when a response is pending and `rsp_ready` is low. A read accepted on one edge gives `rsp_valid` on the next edge. The response stays stable until it is taken, and an accepted write raises no response.
- R11: After a write to every way and index with address bit 20 clear, every read returns status 0 and a read-tag valid bit of 0.
- R12: `inj_data_flip` and `inj_tag_flip` are XORed into the stored data and tag codewords only when a write is accepted. Codeword layout: {parity, check, payload}. Payload bit i sits at Hamming position p(i), the (i+1)-th position from 3 upward that is not a power of two. Check bit j is the XOR of payload bits whose position has bit j set, and the parity bit makes the whole codeword's parity even.
- R13: After reset, `rsp_valid` is low and both side registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = management write, 0 = management read |
| req_addr | input | 39 | Management address (way, index, tag, valid, dirty fields) |
| req_wdata | input | 64 | Write data |
| inj_data_flip | input | 72 | Test-only XOR mask on the stored data codeword |
| inj_tag_flip | input | 26 | Test-only XOR mask on the stored tag codeword |
| rsp_valid | output | 1 | Read response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 64 | Corrected read data |
| rsp_status | output | 3 | 0 clean, 1 data corrected, 2 tag corrected, 3 data uncorrectable, 4 tag uncorrectable |
| reg_sel | input | 1 | 0 = read-tag register, 1 = error-tag register |
| reg_rdata | output | 64 | Selected side register |

## Verification
The main read and write paths are tried in several ways. First comes a full invalidation walk that is then read back. Next, lines that share an index but sit in different ways are written with distinct data. Reads then use upper address bits that differ from the stored tag, which separates addressing by way and index from any tag comparison. Injected flips cover one payload bit, one check bit, the parity bit alone, two data bits, one or two tag bits, and mixes of tag and data errors, which separates correction from detection and pins down the status priority. A held response under back-pressure, with a write waiting behind it, shows that the response stays stable and that the waiting write is neither lost nor taken early.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  typedef enum logic [2:0] {
    ST_CLEAN    = 3'd0,
    ST_DATA_FIX = 3'd1,
    ST_TAG_FIX  = 3'd2,
    ST_DATA_BAD = 3'd3,
    ST_TAG_BAD  = 3'd4
  } rd_status_e;

  // Hamming position of payload bit idx: skip powers of two, start at 3.
  function automatic int hpos(input int idx);
    int p;
    int n;
    p = 2;
    n = 0;
    while (n <= idx) begin
      p = p + 1;
      if ((p & (p - 1)) != 0) n = n + 1;
    end
    return p;
  endfunction

  // Number of Hamming check bits for k payload bits.
  function automatic int hbits(input int k);
    int p;
    p = 0;
    while ((1 << p) < (k + p + 1)) p = p + 1;
    return p;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
  parameter int K = 64
) (
  input  logic [K-1:0]                      din,
  output logic [K+cmp_pkg::hbits(K):0]      cw
);
  localparam int P = cmp_pkg::hbits(K);

  logic [P-1:0] term [K];
  logic [P-1:0] chk;

  for (genvar i = 0; i < K; i++) begin : g_term
    localparam int POS = cmp_pkg::hpos(i);
    assign term[i] = din[i] ? P'(POS) : '0;
  end

  always_comb begin
    chk = '0;
    for (int i = 0; i < K; i++) chk = chk ^ term[i];
  end

  assign cw = {(^din) ^ (^chk), chk, din};
endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
  parameter int K = 64
) (
  input  logic [K+cmp_pkg::hbits(K):0] cw,
  output logic [K-1:0]                 dout,
  output logic                         fixed,
  output logic                         bad
);
  localparam int P = cmp_pkg::hbits(K);

  logic [K-1:0] din;
  logic [P-1:0] chk_st;
  logic [P-1:0] term [K];
  logic [P-1:0] syn;
  logic [K-1:0] flip;
  logic         odd;

  assign din    = cw[K-1:0];
  assign chk_st = cw[K+P-1:K];
  assign odd    = ^cw;

  for (genvar i = 0; i < K; i++) begin : g_bit
    localparam int POS = cmp_pkg::hpos(i);
    assign term[i] = din[i] ? P'(POS) : '0;
    assign flip[i] = (syn == P'(POS));
  end

  always_comb begin
    syn = chk_st;
    for (int i = 0; i < K; i++) syn = syn ^ term[i];
  end

  // Odd overall parity: one error, correct it (a check or parity hit flips nothing).
  // Even parity with a syndrome: two errors, report only.
  assign dout  = odd ? (din ^ flip) : din;
  assign fixed = odd;
  assign bad   = !odd && (syn != '0);
endmodule

// File: rtl/cmp_array.sv
module cmp_array #(
  parameter int LINES = 256,
  parameter int DCW_W = 72,
  parameter int TCW_W = 26
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [$clog2(LINES)-1:0] line,
  input  logic [DCW_W-1:0]         wr_dcw,
  input  logic [TCW_W-1:0]         wr_tcw,
  output logic [DCW_W-1:0]         rd_dcw_q,
  output logic [TCW_W-1:0]         rd_tcw_q
);
  logic [DCW_W-1:0] dmem [LINES];
  logic [TCW_W-1:0] tmem [LINES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      dmem[line] <= wr_dcw;
      tmem[line] <= wr_tcw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_dcw_q <= '0;
      rd_tcw_q <= '0;
    end else if (rd_en) begin
      rd_dcw_q <= dmem[line];
      rd_tcw_q <= tmem[line];
    end
  end
endmodule

// File: rtl/cache_mgmt_port.sv
module cache_mgmt_port #(
  parameter int ADDR_W    = 39,
  parameter int DATA_W    = 64,
  parameter int TAG_W     = 20,
  parameter int WAYS      = 4,
  parameter int SETS      = 64,
  parameter int OFS_W     = 3,
  parameter int VALID_BIT = 20,
  parameter int DIRTY_BIT = 19,
  parameter int REG_W     = 64
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic                                  req_write,
  input  logic [ADDR_W-1:0]                     req_addr,
  input  logic [DATA_W-1:0]                     req_wdata,
  input  logic [DATA_W+cmp_pkg::hbits(DATA_W):0] inj_data_flip,
  input  logic [TAG_W+cmp_pkg::hbits(TAG_W):0]   inj_tag_flip,
  output logic                                  rsp_valid,
  input  logic                                  rsp_ready,
  output logic [DATA_W-1:0]                     rsp_data,
  output logic [2:0]                            rsp_status,
  input  logic                                  reg_sel,
  output logic [REG_W-1:0]                      reg_rdata
);
  import cmp_pkg::*;

  localparam int IDX_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LINE_W  = IDX_W + WAY_W;
  localparam int LINES   = WAYS * SETS;
  localparam int IDX_LSB = OFS_W;
  localparam int WAY_LSB = IDX_LSB + IDX_W;
  localparam int TADR_W  = TAG_W - 2;
  localparam int DCW_W   = DATA_W + hbits(DATA_W) + 1;
  localparam int TCW_W   = TAG_W + hbits(TAG_W) + 1;
  localparam int ELOG_W  = ADDR_W + TAG_W;
  localparam int RTAG_W  = TCW_W;

  // request side
  logic              acc;
  logic [LINE_W-1:0] line;
  logic [TAG_W-1:0]  wr_tag;
  logic [DCW_W-1:0]  enc_dcw;
  logic [TCW_W-1:0]  enc_tcw;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign line      = {req_addr[WAY_LSB +: WAY_W], req_addr[IDX_LSB +: IDX_W]};
  assign wr_tag    = {req_addr[VALID_BIT], req_addr[DIRTY_BIT],
                      req_addr[ADDR_W-1 -: TADR_W]};

  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_addr[OFS_W-1:0],
                              req_addr[DIRTY_BIT-1:WAY_LSB+WAY_W]};

  secded_enc #(.K(DATA_W)) u_denc (.din(req_wdata), .cw(enc_dcw));
  secded_enc #(.K(TAG_W))  u_tenc (.din(wr_tag),    .cw(enc_tcw));

  // storage with registered read
  logic [DCW_W-1:0] rd_dcw_q;
  logic [TCW_W-1:0] rd_tcw_q;

  cmp_array #(.LINES(LINES), .DCW_W(DCW_W), .TCW_W(TCW_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc && req_write),
    .rd_en    (acc && !req_write),
    .line     (line),
    .wr_dcw   (enc_dcw ^ inj_data_flip),
    .wr_tcw   (enc_tcw ^ inj_tag_flip),
    .rd_dcw_q (rd_dcw_q),
    .rd_tcw_q (rd_tcw_q)
  );

  // response stage
  logic              rsp_valid_q;
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rd_addr_q   <= '0;
    end else begin
      if (acc && !req_write) begin
        rsp_valid_q <= 1'b1;
        rd_addr_q   <= req_addr;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;

  logic [TAG_W-1:0] tag_fix;
  logic             d_fixed, d_bad, t_fixed, t_bad;
  rd_status_e       st;

  secded_dec #(.K(DATA_W)) u_ddec (
    .cw(rd_dcw_q), .dout(rsp_data), .fixed(d_fixed), .bad(d_bad));
  secded_dec #(.K(TAG_W)) u_tdec (
    .cw(rd_tcw_q), .dout(tag_fix), .fixed(t_fixed), .bad(t_bad));

  always_comb begin
    if (t_bad)        st = ST_TAG_BAD;
    else if (d_bad)   st = ST_DATA_BAD;
    else if (t_fixed) st = ST_TAG_FIX;
    else if (d_fixed) st = ST_DATA_FIX;
    else              st = ST_CLEAN;
  end

  assign rsp_status = st;

  // side registers
  logic [RTAG_W-1:0] rtag_q;
  logic [ELOG_W-1:0] elog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtag_q <= '0;
      elog_q <= '0;
    end else if (rsp_valid_q) begin
      rtag_q <= {rd_tcw_q[TCW_W-1:TAG_W], tag_fix};
      if (t_bad || d_bad) elog_q <= {rd_addr_q, rd_tcw_q[TAG_W-1:0]};
    end
  end

  assign reg_rdata = reg_sel ? REG_W'(elog_q) : REG_W'(rtag_q);
endmodule

// File: rtl/cmp_checker.sv
module cmp_checker #(
  parameter int ADDR_W = 39,
  parameter int DATA_W = 64,
  parameter int ELOG_W = 59
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [2:0]        rsp_status,
  input logic [ADDR_W-1:0] rd_addr_q,
  input logic [ELOG_W-1:0] elog_q
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid); // R10
  AST_NO_RSP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !rsp_valid); // R10
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status)); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R10
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status <= 3'd4); // R6
  AST_ERRLOG_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status >= 3'd3 |=> elog_q[ELOG_W-1 -: ADDR_W] == $past(rd_addr_q)); // R8
  AST_ERRLOG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status < 3'd3 |=> $stable(elog_q)); // R8
endmodule

bind cache_mgmt_port cmp_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .ELOG_W (ADDR_W + TAG_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data),
  .rsp_status (rsp_status),
  .rd_addr_q  (rd_addr_q),
  .elog_q     (elog_q)
);

// File: tb/cache_mgmt_port_tb_top.sv
`timescale 1ns/1ps
module cache_mgmt_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [38:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [71:0] inj_data_flip = '0;
  logic [25:0] inj_tag_flip = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic [2:0]  rsp_status;
  logic        reg_sel = 1'b0;
  logic [63:0] reg_rdata;

  always #2 clk = ~clk;

  cache_mgmt_port dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .inj_data_flip(inj_data_flip), .inj_tag_flip(inj_tag_flip),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_status(rsp_status), .reg_sel(reg_sel), .reg_rdata(reg_rdata));

  int n_chk = 0;
  int n_err = 0;
  bit auto_sel = 1'b1;
  bit run_cmp = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  // ---------------- behavioural code model (R12 layout) ----------------
  function automatic logic [7:0] hsum(input logic [63:0] d, input int k);
    logic [7:0] s;
    int p;
    s = '0;
    p = 2;
    for (int i = 0; i < k; i++) begin
      p++;
      while ((p & (p - 1)) == 0) p++;
      if (d[i]) s = s ^ 8'(p);
    end
    return s;
  endfunction

  function automatic logic [63:0] hflip(input logic [63:0] d, input int k,
                                        input logic [7:0] syn);
    logic [63:0] r;
    int p;
    r = d;
    p = 2;
    for (int i = 0; i < k; i++) begin
      p++;
      while ((p & (p - 1)) == 0) p++;
      if (8'(p) == syn) r[i] = ~r[i];
    end
    return r;
  endfunction

  function automatic logic [71:0] enc_d(input logic [63:0] d);
    logic [6:0] c;
    c = hsum(d, 64) & 8'h7f;
    return {(^d) ^ (^c), c, d};
  endfunction

  function automatic logic [25:0] enc_t(input logic [19:0] t);
    logic [4:0] c;
    c = 5'(hsum({44'b0, t}, 20));
    return {(^t) ^ (^c), c, t};
  endfunction

  // kind: 0 clean, 1 corrected, 2 uncorrectable
  task automatic dec(input logic [63:0] d, input logic [7:0] c, input logic odd,
                     input int k, output logic [63:0] o, output int kind);
    logic [7:0] syn;
    syn = hsum(d, k) ^ c;
    o = d;
    if (odd) begin
      o = hflip(d, k, syn);
      kind = 1;
    end else if (syn != 0) kind = 2;
    else kind = 0;
  endtask

  function automatic logic [38:0] mk(input logic [17:0] ta, input logic v,
                                     input logic dt, input logic [1:0] w,
                                     input logic [5:0] ix);
    return {ta, v, dt, 8'h00, w, ix, 3'b000};
  endfunction

  function automatic string st_req(input logic [2:0] s);
    if (s == 3'd0) return "R2";
    if (s == 3'd1) return "R3";
    if (s == 3'd2) return "R5";
    if (s == 3'd3) return "R4";
    return "R6";
  endfunction

  // ---------------- cycle model ----------------
  logic [71:0] m_d [256];
  logic [25:0] m_t [256];
  logic        m_vld;
  logic [63:0] p_data;
  logic [2:0]  p_st;
  logic [25:0] p_rt;
  logic [58:0] p_et;
  logic        p_ue;
  logic [25:0] m_rt;
  logic [58:0] m_et;

  always @(posedge clk or negedge rst_n) begin : mdl
    logic [7:0]  ln;
    logic [71:0] dc;
    logic [25:0] tc;
    logic [63:0] dout, tout;
    int          dk, tk;
    logic [2:0]  s;
    if (!rst_n) begin
      m_vld <= 1'b0; m_rt <= '0; m_et <= '0;
      p_data <= '0; p_st <= '0; p_rt <= '0; p_et <= '0; p_ue <= 1'b0;
    end else begin
      if (m_vld) begin
        m_rt <= p_rt;
        if (p_ue) m_et <= p_et;
      end
      if (m_vld && rsp_ready) m_vld <= 1'b0;
      if (req_valid && (!m_vld || rsp_ready)) begin
        ln = {req_addr[10:9], req_addr[8:3]};
        if (req_write) begin
          m_d[ln] <= enc_d(req_wdata) ^ inj_data_flip;
          m_t[ln] <= enc_t({req_addr[20], req_addr[19], req_addr[38:21]}) ^ inj_tag_flip;
        end else begin
          dc = m_d[ln];
          tc = m_t[ln];
          dec(dc[63:0], {1'b0, dc[70:64]}, ^dc, 64, dout, dk);
          dec({44'b0, tc[19:0]}, {3'b0, tc[24:20]}, ^tc, 20, tout, tk);
          if (tk == 2) s = 3'd4;
          else if (dk == 2) s = 3'd3;
          else if (tk == 1) s = 3'd2;
          else if (dk == 1) s = 3'd1;
          else s = 3'd0;
          p_data <= dout;
          p_st   <= s;
          p_rt   <= {tc[25:20], tout[19:0]};
          p_et   <= {req_addr, tc[19:0]};
          p_ue   <= (s >= 3'd3);
          m_vld  <= 1'b1;
        end
      end
    end
  end

  // compare every cycle, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rst_n && run_cmp) begin
      chk("R10", "req_ready", 64'(req_ready), 64'(!m_vld || rsp_ready));
      chk("R10", "rsp_valid", 64'(rsp_valid), 64'(m_vld));
      if (m_vld) begin
        chk(p_st == 3'd1 ? "R3" : "R1", "rsp_data", rsp_data, p_data);
        chk(st_req(p_st), "rsp_status", 64'(rsp_status), 64'(p_st));
      end
      if (reg_sel) chk("R8", "err_tag_reg", reg_rdata, 64'(m_et));
      else         chk("R7", "read_tag_reg", reg_rdata, 64'(m_rt));
    end
  end

  always @(negedge clk) if (auto_sel) reg_sel = ~reg_sel;

  // ---------------- drivers ----------------
  task automatic do_write(input logic [38:0] a, input logic [63:0] d,
                          input logic [71:0] fd, input logic [25:0] ft);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    inj_data_flip = fd; inj_tag_flip = ft;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; inj_data_flip = '0; inj_tag_flip = '0;
  endtask

  task automatic do_read(input logic [38:0] a, output logic [63:0] d,
                         output logic [2:0] st);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d = rsp_data;
    st = rsp_status;
  endtask

  task automatic rd_reg(input logic sel, output logic [63:0] v);
    @(negedge clk);
    auto_sel = 1'b0;
    reg_sel = sel;
    #1 v = reg_rdata;
    auto_sel = 1'b1;
  endtask

  // injection case on way 0, index 10
  task automatic inj_case(input string req, input logic [71:0] fd,
                          input logic [25:0] ft, input logic [2:0] exp_st);
    logic [38:0] a;
    logic [63:0] d, rv;
    logic [2:0]  st;
    logic [19:0] tg;
    a  = mk(18'h1B2C3, 1'b1, 1'b0, 2'd0, 6'd10);
    tg = {1'b1, 1'b0, 18'h1B2C3};
    do_write(a, 64'hA5A5_0F0F_3C3C_9696, fd, ft);
    do_read(a, d, st);
    chk(req, "status", 64'(st), 64'(exp_st));
    if (exp_st <= 3'd2) chk(req, "data", d, 64'hA5A5_0F0F_3C3C_9696);
    rd_reg(1'b0, rv);
    if (exp_st != 3'd4) chk(req, "corrected tag", rv & 64'hFFFFF, 64'(tg));
    chk("R7", "raw tag check bits", rv >> 20, 64'(enc_t(tg) >> 20) ^ 64'(ft >> 20));
    if (exp_st >= 3'd3) begin
      rd_reg(1'b1, rv);
      chk("R8", "err log", rv, 64'({a, tg ^ ft[19:0]}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] d, rv, elog_before;
    logic [2:0]  st;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R13 reset state
    rd_reg(1'b0, rv); chk("R13", "read_tag_reg after reset", rv, 64'h0);
    rd_reg(1'b1, rv); chk("R13", "err_tag_reg after reset", rv, 64'h0);
    chk("R13", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
    run_cmp = 1'b1;

    // R11 invalidation walk
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 64; i++)
        do_write(mk(18'h00000, 1'b0, 1'b0, 2'(w), 6'(i)), {56'h0, 2'(w), 6'(i)}, '0, '0);
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 64; i++) begin
        do_read(mk(18'h3F0F0, 1'b1, 1'b1, 2'(w), 6'(i)), d, st);
        chk("R11", "walk status", 64'(st), 64'h0);
        rd_reg(1'b0, rv);
        chk("R11", "walk valid bit", 64'(rv[19]), 64'h0);
      end

    // R1 / R2 addressing and tag build
    do_write(mk(18'h2ABCD, 1'b1, 1'b1, 2'd2, 6'd5), 64'hDEAD_BEEF_0123_4567, '0, '0);
    do_write(mk(18'h01234, 1'b1, 1'b0, 2'd1, 6'd5), 64'h1111_2222_3333_4444, '0, '0);
    do_write(mk(18'h3FFFF, 1'b0, 1'b1, 2'd3, 6'd63), 64'hFFFF_FFFF_FFFF_FFFF, '0, '0);
    do_read(mk(18'h00001, 1'b0, 1'b0, 2'd2, 6'd5), d, st);
    chk("R1", "data with mismatching tag", d, 64'hDEAD_BEEF_0123_4567);
    chk("R2", "clean status", 64'(st), 64'h0);
    rd_reg(1'b0, rv);
    chk("R2", "stored tag v/d/addr", rv & 64'hFFFFF, 64'({1'b1, 1'b1, 18'h2ABCD}));
    chk("R7", "read tag register", rv, 64'(enc_t({1'b1, 1'b1, 18'h2ABCD})));
    do_read(mk(18'h01234, 1'b0, 1'b0, 2'd1, 6'd5), d, st);
    chk("R1", "same index other way", d, 64'h1111_2222_3333_4444);
    do_read(mk(18'h00000, 1'b0, 1'b0, 2'd3, 6'd63), d, st);
    chk("R1", "last line", d, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(1'b0, rv);
    chk("R2", "valid=0 dirty=1", 64'(rv[19:18]), 64'h1);

    // R3 / R12 single data errors
    inj_case("R3", 72'h1 << 17, '0, 3'd1);
    inj_case("R12", 72'h1 << 66, '0, 3'd1);
    inj_case("R12", 72'h1 << 71, '0, 3'd1);
    // R4 double data
    inj_case("R4", (72'h1 << 3) | (72'h1 << 40), '0, 3'd3);
    // R5 single tag, payload and check bits
    inj_case("R5", '0, 26'h1 << 7, 3'd2);
    inj_case("R5", '0, 26'h1 << 22, 3'd2);
    // R6 double tag and priorities
    inj_case("R6", '0, (26'h1 << 2) | (26'h1 << 15), 3'd4);
    inj_case("R6", (72'h1 << 5) | (72'h1 << 9), (26'h1 << 0) | (26'h1 << 1), 3'd4);
    inj_case("R4", (72'h1 << 5) | (72'h1 << 9), 26'h1 << 4, 3'd3);
    inj_case("R5", 72'h1 << 33, 26'h1 << 11, 3'd2);

    // R8 log kept on clean read
    rd_reg(1'b1, elog_before);
    do_read(mk(18'h2ABCD, 1'b1, 1'b1, 2'd2, 6'd5), d, st);
    rd_reg(1'b1, rv);
    chk("R8", "log unchanged by clean read", rv, elog_before);

    // R9 overwrite of corrupted line
    do_write(mk(18'h00777, 1'b1, 1'b0, 2'd0, 6'd20), 64'h0, (72'h1 << 1) | (72'h1 << 2),
             (26'h1 << 3) | (26'h1 << 6));
    do_write(mk(18'h00778, 1'b1, 1'b1, 2'd0, 6'd20), 64'h5555_AAAA_5555_AAAA, '0, '0);
    do_read(mk(18'h00778, 1'b1, 1'b1, 2'd0, 6'd20), d, st);
    chk("R9", "status after overwrite", 64'(st), 64'h0);
    chk("R9", "data after overwrite", d, 64'h5555_AAAA_5555_AAAA);

    // R10 back-pressure with a write waiting
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk(18'h0, 1'b0, 1'b0, 2'd1, 6'd5);
    @(negedge clk);
    req_write = 1'b1; req_addr = mk(18'h00042, 1'b1, 1'b0, 2'd1, 6'd6);
    req_wdata = 64'h0BAD_F00D_CAFE_0001;
    for (int c = 0; c < 4; c++) begin
      chk("R10", "rsp held", 64'(rsp_valid), 64'h1);
      chk("R10", "ready low", 64'(req_ready), 64'h0);
      chk("R10", "held data", rsp_data, 64'h1111_2222_3333_4444);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    #0.5 chk("R10", "ready on take", 64'(req_ready), 64'h1);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R10", "no response for write", 64'(rsp_valid), 64'h0);
    do_read(mk(18'h0, 1'b0, 1'b0, 2'd1, 6'd6), d, st);
    chk("R10", "waiting write landed", d, 64'h0BAD_F00D_CAFE_0001);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule